// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block places a direct-mapped cache between a processor's word-access port and a slower memory that transfers whole lines. By default it holds 64 lines of 16 bytes each and works on 32-bit byte addresses. Each line carries a valid flag, a dirty flag and the upper address bits as its tag. Reads and writes that hit complete in the same cycle as the request. A miss stalls the processor while the controller walks its steps. If the line being replaced holds modified data, that line is first written back to memory. The new line is then fetched, and the stalled request is retried as a hit.

Writes follow a write-back, allocate-on-miss policy. A write hit changes only the cached copy and marks the line dirty. A write miss fetches the line first and then merges the bytes selected by the byte enables. Memory sees a write only when a dirty line is evicted.

Back-pressure rules are the same on both ports. On the processor side, `cpu_req_valid` together with the address, write flag, write data and byte enables must stay stable until the cycle in which `cpu_req_ready` is high. That cycle is the transfer, and `cpu_rdata` is valid in it. `cpu_req_ready` is never high without `cpu_req_valid`. On the memory side, `mem_req` together with `mem_we`, `mem_addr` and `mem_wdata` stays stable until `mem_ack` is sampled high. One acknowledge ends one line transfer. On a fetch, `mem_rdata` is taken in the acknowledge cycle.

Top module: `dm_wb_cache`

## Requirements
- R1: The byte address divides into tag = bits 31:10, line index = bits 9:4 and byte offset = bits 3:0. The line index is the line address modulo 64, so byte address 1200 (0x4B0) selects line 11 with tag 1.
- R2: A request hits when the indexed line is valid and its stored tag equals the address tag. On a hit, `cpu_req_ready` rises in the same cycle as `cpu_req_valid`, and for a read `cpu_rdata` carries the word in that cycle.
- R3: Reset clears every valid flag, so the first access to any line after reset misses. While reset is applied and idle, `cpu_req_ready` and `mem_req` are low.
- R4: A write hit updates only the cached bytes selected by `cpu_be` (bit k selects byte k, bits 8k+7:8k) and marks the line dirty. No memory write is issued.
- R5: When a miss replaces a valid dirty line, the full 128-bit line is written to memory at {stored tag, index, 4'b0000} before the fetch. A clean or invalid victim causes no memory write.
- R6: A write miss fetches the line first and then merges the write into it (allocate on miss).
- R7: While a miss is serviced, `cpu_req_ready` stays low. In the cycle after the fetch acknowledge, the held request completes as a hit.
- R8: A memory transfer holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until `mem_ack`. A fetch asks for {address tag, index, 4'b0000}, and `mem_addr[3:0]` is always zero.
- R9: Address bits 3:2 choose the 32-bit word within the line (word k is line bits 32k+31:32k). Bits 1:0 are ignored.
- R10: A fetch loads the whole line, sets valid, clears dirty and stores the new tag in one cycle, so evicting a freshly fetched line issues no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request completes this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_rdata | output | 32 | Read data, valid when ready is high |
| mem_req | output | 1 | Line transfer requested |
| mem_we | output | 1 | 1 = write-back, 0 = fetch |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Line written back |
| mem_ack | input | 1 | Transfer done this cycle |
| mem_rdata | input | 128 | Fetched line, taken with mem_ack |

## Verification
A hit produces `cpu_req_ready` and read data combinationally in the cycle the request is presented. The bench therefore drives the request just after a falling edge and samples one time unit later in that same cycle, expecting zero wait cycles.

A miss becomes visible at the memory port one rising edge later, and the request completes in the cycle after the fetch acknowledge. The bench records whether the sample just before ready saw a fetch acknowledge, and it counts write-backs in its memory model at each write acknowledge. The model's acknowledge latency varies from one to three cycles, so the checks rely on the handshake order and never on a fixed miss length.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_LOOK  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2
  } cstate_t;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             mark_dirty,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag
);
  localparam int DEPTH = 1 << IDX_W;

  logic             valid_q [DEPTH];
  logic             dirty_q [DEPTH];
  logic [TAG_W-1:0] tag_q   [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        valid_q[i] <= 1'b0;
        dirty_q[i] <= 1'b0;
      end
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (mark_dirty) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx] <= fill_tag;
  end

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_q[idx];
endmodule

// File: rtl/cache_line_store.sv
module cache_line_store #(
  parameter int IDX_W  = 6,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  output logic [LINE_W-1:0] rd_line
);
  localparam int DEPTH = 1 << IDX_W;

  logic [LINE_W-1:0] line_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) line_q[idx] <= wr_line;
  end

  assign rd_line = line_q[idx];
endmodule

// File: rtl/cache_word_lane.sv
module cache_word_lane #(
  parameter int LINE_W = 128,
  parameter int WSEL_W = 2
) (
  input  logic [LINE_W-1:0] line_in,
  input  logic [WSEL_W-1:0] word_sel,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output logic [LINE_W-1:0] line_out,
  output logic [31:0]       word_out
);
  localparam int WORDS = LINE_W / 32;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < 4; b++) begin : g_byte
      assign line_out[w*32 + b*8 +: 8] =
        (word_sel == WSEL_W'(w) && be[b]) ? wdata[b*8 +: 8]
                                          : line_in[w*32 + b*8 +: 8];
    end
  end

  assign word_out = line_in[word_sel*32 +: 32];
endmodule

// File: rtl/cache_fsm.sv
module cache_fsm
  import cache_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    req_we,
  input  logic    hit,
  input  logic    victim_dirty,
  input  logic    mem_ack,
  output cstate_t state,
  output logic    req_ready,
  output logic    mem_req,
  output logic    mem_we,
  output logic    fill_en,
  output logic    hit_wr
);
  cstate_t nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_LOOK;
    else        state <= nxt;
  end

  always_comb begin
    nxt       = state;
    req_ready = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    fill_en   = 1'b0;
    hit_wr    = 1'b0;
    case (state)
      ST_LOOK: begin
        if (req_valid) begin
          if (hit) begin
            req_ready = 1'b1;
            hit_wr    = req_we;
          end else begin
            nxt = victim_dirty ? ST_EVICT : ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) nxt = ST_FILL;
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          fill_en = 1'b1;
          nxt     = ST_LOOK;
        end
      end
      default: nxt = ST_LOOK;
    endcase
  end
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int NUM_LINES  = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req_valid,
  output logic                    cpu_req_ready,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [31:0]             cpu_wdata,
  input  logic [3:0]              cpu_be,
  output logic [31:0]             cpu_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LINE_BYTES*8-1:0] mem_wdata,
  input  logic                    mem_ack,
  input  logic [LINE_BYTES*8-1:0] mem_rdata
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WSEL_W = $clog2(LINE_BYTES / 4);

  cstate_t           state;
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic [WSEL_W-1:0] word_sel;
  logic              line_valid, line_dirty;
  logic [TAG_W-1:0]  line_tag;
  logic              hit, victim_dirty;
  logic              fill_en, hit_wr;
  logic [LINE_W-1:0] rd_line, merged_line, wr_line;
  logic [1:0]        unused_byte_bits;

  assign req_idx          = cpu_addr[OFF_W +: IDX_W];
  assign req_tag          = cpu_addr[ADDR_W-1 -: TAG_W];
  assign word_sel         = cpu_addr[2 +: WSEL_W];
  assign unused_byte_bits = cpu_addr[1:0];

  assign hit          = line_valid && (line_tag == req_tag);
  assign victim_dirty = line_valid && line_dirty;

  cache_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx        (req_idx),
    .fill_en    (fill_en),
    .fill_tag   (req_tag),
    .mark_dirty (hit_wr),
    .rd_valid   (line_valid),
    .rd_dirty   (line_dirty),
    .rd_tag     (line_tag)
  );

  cache_word_lane #(.LINE_W(LINE_W), .WSEL_W(WSEL_W)) u_lane (
    .line_in  (rd_line),
    .word_sel (word_sel),
    .be       (cpu_be),
    .wdata    (cpu_wdata),
    .line_out (merged_line),
    .word_out (cpu_rdata)
  );

  assign wr_line = fill_en ? mem_rdata : merged_line;

  cache_line_store #(.IDX_W(IDX_W), .LINE_W(LINE_W)) u_lines (
    .clk     (clk),
    .idx     (req_idx),
    .wr_en   (fill_en | hit_wr),
    .wr_line (wr_line),
    .rd_line (rd_line)
  );

  cache_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (cpu_req_valid),
    .req_we       (cpu_we),
    .hit          (hit),
    .victim_dirty (victim_dirty),
    .mem_ack      (mem_ack),
    .state        (state),
    .req_ready    (cpu_req_ready),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .fill_en      (fill_en),
    .hit_wr       (hit_wr)
  );

  assign mem_addr  = {(state == ST_EVICT) ? line_tag : req_tag, req_idx, {OFF_W{1'b0}}};
  assign mem_wdata = rd_line;
endmodule

// File: rtl/cache_checks.sv
module cache_checks #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LINE_W-1:0] mem_wdata,
  input logic              mem_ack
);
  // R2: ready only answers a presented request
  a_r2_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> cpu_req_valid);

  // R7: no completion while a line transfer is in flight
  a_r7_stall_during_mem: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_req_ready);

  // R8: transfer fields hold until acknowledged
  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                               && $stable(mem_wdata)));

  // R8: line-aligned memory address
  a_r8_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0));

  // R8: fetch targets the line of the held request
  a_r8_fetch_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (cpu_req_valid
                              && mem_addr[ADDR_W-1:OFF_W] == cpu_addr[ADDR_W-1:OFF_W]));

  // R5: a finished write-back is followed by the fetch
  a_r5_evict_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));
endmodule

bind dm_wb_cache cache_checks #(
  .ADDR_W (ADDR_W),
  .LINE_W (LINE_BYTES * 8),
  .OFF_W  ($clog2(LINE_BYTES))
) u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_ready (cpu_req_ready),
  .cpu_addr      (cpu_addr),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .mem_ack       (mem_ack)
);

// File: tb/dm_wb_cache_test.sv
module dm_wb_cache_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic        hit;
    logic        wb;
  } vec_t;

  // fields: we, addr, be, wdata, expected hit, expected write-back
  localparam vec_t VECS [14] = '{
    '{1'b0, 32'h0000_04B0, 4'h0, 32'h0,         1'b0, 1'b0}, // R1 R3: 1200 -> line 11, cold miss
    '{1'b0, 32'h0000_04B4, 4'h0, 32'h0,         1'b1, 1'b0}, // R2 R9: same line, word 1
    '{1'b1, 32'h0000_04B8, 4'hF, 32'h1122_3344, 1'b1, 1'b0}, // R4: write hit, no memory write
    '{1'b0, 32'h0000_04B8, 4'h0, 32'h0,         1'b1, 1'b0}, // R4: cached copy updated
    '{1'b0, 32'h0000_00B0, 4'h0, 32'h0,         1'b0, 1'b1}, // R5: dirty victim written back
    '{1'b0, 32'h0000_04B8, 4'h0, 32'h0,         1'b0, 1'b0}, // R5: memory got the data
    '{1'b1, 32'h0000_08BC, 4'h3, 32'hDEAD_BEEF, 1'b0, 1'b0}, // R6 R10: write miss, clean victim
    '{1'b0, 32'h0000_08BC, 4'h0, 32'h0,         1'b1, 1'b0}, // R6: merged bytes
    '{1'b1, 32'h0000_08B1, 4'h8, 32'hAA00_0000, 1'b1, 1'b0}, // R9: low bits ignored
    '{1'b0, 32'h0000_08B0, 4'h0, 32'h0,         1'b1, 1'b0}, // R9: word 0 changed
    '{1'b0, 32'h0000_04B0, 4'h0, 32'h0,         1'b0, 1'b1}, // R5: evict dirty tag 2
    '{1'b0, 32'h0000_08BC, 4'h0, 32'h0,         1'b0, 1'b0}, // R10: fetched line clean
    '{1'b0, 32'h0000_0020, 4'h0, 32'h0,         1'b0, 1'b0}, // R1: line 2
    '{1'b0, 32'h0000_0FF0, 4'h0, 32'h0,         1'b0, 1'b0}  // R1: line 63, tag 3
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_req_valid = 1'b0;
  logic         cpu_req_ready;
  logic         cpu_we = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic [3:0]   cpu_be = '0;
  logic [31:0]  cpu_rdata;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic         mem_ack = 1'b0;
  logic [127:0] mem_rdata = '0;

  int checks = 0;
  int fails  = 0;
  int wb_cnt = 0;
  int wait_cnt = 0;
  int lat = 1;
  bit done = 0;

  logic [127:0] back   [256];
  logic [31:0]  golden [1024];

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_wb_cache uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_be(cpu_be), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // line memory with a latency of 1 to 3 cycles per transfer
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (!rst_n) begin
      wait_cnt <= 0;
    end else if (mem_req && !mem_ack) begin
      if (wait_cnt >= lat) begin
        mem_ack  <= 1'b1;
        wait_cnt <= 0;
        lat      <= (lat % 3) + 1;
        if (mem_we) begin
          back[mem_addr[11:4]] <= mem_wdata;
          wb_cnt <= wb_cnt + 1;
        end else begin
          mem_rdata <= back[mem_addr[11:4]];
        end
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int n);
    int          waits = 0;
    logic        prev_fill = 1'b0;
    int          wb0;
    logic [31:0] exp, got, merged;
    wb0 = wb_cnt;
    exp = golden[v.addr[11:2]];
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_we = v.we; cpu_addr = v.addr; cpu_wdata = v.wdata; cpu_be = v.be;
    #1;
    while (!cpu_req_ready) begin
      prev_fill = mem_req && mem_ack && !mem_we;
      @(negedge clk); #1;
      waits++;
    end
    got = cpu_rdata;
    @(posedge clk); #1;
    cpu_req_valid = 1'b0;
    check((waits == 0) == v.hit, $sformatf("R2 hit/miss vec%0d", n), 32'(waits), {31'b0, v.hit});
    check((wb_cnt - wb0) == (v.wb ? 1 : 0), $sformatf("R5 write-back count vec%0d", n),
          32'(wb_cnt - wb0), {31'b0, v.wb});
    if (!v.hit)
      check(prev_fill, $sformatf("R7 ready after fetch ack vec%0d", n), {31'b0, prev_fill}, 32'd1);
    if (!v.we) begin
      check(got == exp, $sformatf("R9 read data vec%0d", n), got, exp);
    end else begin
      merged = exp;
      for (int b = 0; b < 4; b++)
        if (v.be[b]) merged[b*8 +: 8] = v.wdata[b*8 +: 8];
      golden[v.addr[11:2]] = merged;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++)
      for (int w = 0; w < 4; w++) begin
        back[i][w*32 +: 32]  = 32'hC000_0000 | 32'(i*16 + w*4);
        golden[i*4 + w]      = 32'hC000_0000 | 32'(i*16 + w*4);
      end

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R3: idle outputs under reset
    check(!cpu_req_ready, "R3 ready low in reset", {31'b0, cpu_req_ready}, 32'd0);
    check(!mem_req, "R3 mem_req low in reset", {31'b0, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_req, "R3 mem_req low after reset", {31'b0, mem_req}, 32'd0);

    for (int n = 0; n < 14; n++) run_vec(VECS[n], n);

    // R3: reset again, a previously hit line must miss
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    run_vec('{1'b0, 32'h0000_0020, 4'h0, 32'h0, 1'b0, 1'b0}, 100); // R3 miss after reset
    run_vec('{1'b0, 32'h0000_0024, 4'h0, 32'h0, 1'b1, 1'b0}, 101); // R2 hit after refill
    // R4 R6: partial write miss then readback of untouched bytes
    run_vec('{1'b1, 32'h0000_0306, 4'h4, 32'h0077_0000, 1'b0, 1'b0}, 102);
    run_vec('{1'b0, 32'h0000_0304, 4'h0, 32'h0, 1'b1, 1'b0}, 103);
    run_vec('{1'b0, 32'h0000_0300, 4'h0, 32'h0, 1'b1, 1'b0}, 104);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule